// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block watches the memory requests of several hardware thread contexts that share one memory. It keeps one address reservation for each context so that a store-conditional can tell whether another store has reached its line since that context's locked load. Each context owns a reservation flag and a reserved physical address. A locked load arms the issuing context's reservation. A store-conditional checks that reservation and returns a result code. Every store that is actually carried out disarms each reservation that covers its 16-byte granule, in every context.

Requests arrive on a valid/ready channel, at most one per cycle. `req_ready` is held high, so a request is taken in any cycle in which `req_valid` is high and the block never applies back-pressure. One cycle after each accepted request, a response strobe carries three things: whether the request was a store-conditional, its result code, and whether the store may write memory. Each context also keeps a saturating count of consecutive store-conditional failures. A periodic warning pulse names a context that appears to be spinning without making progress.

Top module: `resv_monitor`

## Requirements
- R1: A locked load (`req_store`=0, `req_locked`=1) records its address as the issuing context's reservation address and sets that context's reservation flag, whether or not `req_uncached` is set.
- R2: A cacheable store-conditional (`req_store`=1, `req_locked`=1, `req_uncached`=0) succeeds only when the issuer's flag is set and the reserved address equals the store address with bits [3:0] ignored. On success it reports `rsp_code`=1 with `rsp_store_ok`=1. `rsp_valid` rises exactly one cycle after every accepted request.
- R3: A failing cacheable store-conditional reports `rsp_code`=0 with `rsp_store_ok`=0 and clears the issuer's reservation flag.
- R4: A store-conditional with `req_uncached`=1 skips the reservation check. It reports `rsp_code`=2 with `rsp_store_ok`=1 and resets the issuer's failure count to 0.
- R5: Each context's failure count (`fail_count` bits [i*FAIL_W +: FAIL_W] for context i) rises by one on each failing cacheable store-conditional. It returns to 0 on any successful or uncached store-conditional and saturates at 2^FAIL_W-1.
- R6: When a context's run of consecutive failures reaches a multiple of WARN_PERIOD, `warn_valid` pulses for one cycle together with the response, and `warn_ctx` gives that context. This continues after the count has saturated.
- R7: A performed store clears the reservation flag of every context, the issuer included, whose reserved address matches at 16-byte granularity. Performed stores are plain stores, successful store-conditionals and uncached store-conditionals. A plain store (`req_locked`=0) always reports `rsp_store_ok`=1.
- R8: Reset clears all reservation flags, reservation addresses and failure counts, and drives `rsp_valid` and `warn_valid` low.
- R9: A plain load (`req_store`=0, `req_locked`=0) changes no reservation and no count. Every response that is not a store-conditional has `rsp_sc`=0 and `rsp_code`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1; request accepted when valid |
| req_ctx | input | CTX_W | Issuing context number |
| req_addr | input | AW | Physical address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_locked | input | 1 | Locked load or store-conditional |
| req_uncached | input | 1 | Target is uncacheable |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_sc | output | 1 | Response belongs to a store-conditional |
| rsp_code | output | 2 | 0 fail, 1 success, 2 uncached bypass |
| rsp_store_ok | output | 1 | Store may be written to memory |
| warn_valid | output | 1 | One-cycle failure-run warning |
| warn_ctx | output | CTX_W | Context named by the warning |
| fail_count | output | NCTX*FAIL_W | Per-context consecutive failure counts |

## Verification
Every result of a request is registered once. The response fields, the updated failure count of the issuing context and the warning all become visible after the first rising edge that samples the request. A reservation change is seen by the next request. The bench drives each request on a falling edge and queues its expected outcome from a model written from the requirements. A monitor on the following falling edge pops that entry whenever `rsp_valid` is high, so every comparison falls exactly one cycle after its stimulus and half a period away from any edge.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    SC_FAIL     = 2'd0,
    SC_PASS     = 2'd1,
    SC_UNCACHED = 2'd2
  } sc_code_e;
endpackage

// File: rtl/resv_slot.sv
// One context's reservation: flag plus reserved granule address.
module resv_slot #(
  parameter int AW        = 32,
  parameter int GRAN_BITS = 4,
  localparam int GW       = AW - GRAN_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,      // locked load from this context
  input  logic          clr_own_i,  // failed store-conditional from this context
  input  logic          snoop_i,    // some store is being performed
  input  logic [GW-1:0] gran_i,     // request address, granule part
  output logic          hit_o       // armed and covering gran_i
);
  logic          flag_q;
  logic [GW-1:0] gran_q;
  logic          same_gran;

  assign same_gran = (gran_q == gran_i);
  assign hit_o     = flag_q && same_gran;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      gran_q <= '0;
    end else if (set_i) begin
      flag_q <= 1'b1;
      gran_q <= gran_i;
    end else if (clr_own_i || (snoop_i && same_gran)) begin
      flag_q <= 1'b0;
    end
  end

  AST_LL_ARMS: assert property (@(posedge clk) disable iff (!rst_n) set_i |=> flag_q); // R1
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) !set_i |=> $stable(gran_q)); // R1
  AST_SNOOP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n) (snoop_i && same_gran && !set_i) |=> !flag_q); // R7
  AST_OWN_FAIL_DISARMS: assert property (@(posedge clk) disable iff (!rst_n) (clr_own_i && !set_i) |=> !flag_q); // R3
endmodule

// File: rtl/fail_tracker.sv
// Consecutive store-conditional failure count with a periodic warning.
module fail_tracker #(
  parameter int FAIL_W      = 20,
  parameter int WARN_PERIOD = 100000,
  localparam int SUB_W      = (WARN_PERIOD > 2) ? $clog2(WARN_PERIOD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fail_i,
  input  logic              pass_i,
  output logic [FAIL_W-1:0] cnt_o,
  output logic              warn_o
);
  localparam logic [FAIL_W-1:0] CNT_MAX  = '1;
  localparam logic [SUB_W-1:0]  SUB_LAST = SUB_W'(WARN_PERIOD - 1);

  logic [FAIL_W-1:0] cnt_q;
  logic [SUB_W-1:0]  sub_q;
  logic              warn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sub_q  <= '0;
      warn_q <= 1'b0;
    end else begin
      warn_q <= 1'b0;
      if (pass_i) begin
        cnt_q <= '0;
        sub_q <= '0;
      end else if (fail_i) begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (sub_q == SUB_LAST) begin
          sub_q  <= '0;
          warn_q <= 1'b1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign warn_o = warn_q;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (fail_i && !pass_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX); // R5
  AST_PASS_ZEROES: assert property (@(posedge clk) disable iff (!rst_n) pass_i |=> cnt_q == '0); // R5
  AST_WARN_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n) $rose(warn_q) |-> $past(fail_i)); // R6
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int NCTX        = 4,
  parameter int AW          = 32,
  parameter int GRAN_BITS   = 4,
  parameter int FAIL_W      = 20,
  parameter int WARN_PERIOD = 100000,
  localparam int CTX_W      = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int GW         = AW - GRAN_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [CTX_W-1:0]       req_ctx,
  input  logic [AW-1:0]          req_addr,
  input  logic                   req_store,
  input  logic                   req_locked,
  input  logic                   req_uncached,
  output logic                   rsp_valid,
  output logic                   rsp_sc,
  output logic [1:0]             rsp_code,
  output logic                   rsp_store_ok,
  output logic                   warn_valid,
  output logic [CTX_W-1:0]       warn_ctx,
  output logic [NCTX*FAIL_W-1:0] fail_count
);
  import resv_pkg::*;

  logic [GW-1:0]        req_gran;
  logic                 unused_low;
  logic                 is_ll, is_sc, is_plain_st;
  logic                 own_hit;
  logic                 sc_pass, sc_fail, sc_unc, perform;
  logic [NCTX-1:0]      sel, hit_vec, warn_vec;
  logic [FAIL_W-1:0]    cnt_arr [NCTX];
  sc_code_e             code_d;

  logic                 rsp_valid_q, rsp_sc_q, rsp_ok_q;
  logic [1:0]           rsp_code_q;

  assign req_ready  = 1'b1;
  assign req_gran   = req_addr[AW-1:GRAN_BITS];
  assign unused_low = ^req_addr[GRAN_BITS-1:0];

  // request classification
  assign is_ll       = req_valid && !req_store && req_locked;
  assign is_sc       = req_valid && req_store && req_locked;
  assign is_plain_st = req_valid && req_store && !req_locked;

  always_comb begin
    own_hit = 1'b0;
    for (int i = 0; i < NCTX; i++)
      if (req_ctx == CTX_W'(i)) own_hit = hit_vec[i];
  end

  assign sc_unc  = is_sc && req_uncached;
  assign sc_pass = is_sc && !req_uncached && own_hit;
  assign sc_fail = is_sc && !req_uncached && !own_hit;
  assign perform = is_plain_st || sc_pass || sc_unc;

  always_comb begin
    code_d = SC_FAIL;
    if (sc_unc)       code_d = SC_UNCACHED;
    else if (sc_pass) code_d = SC_PASS;
  end

  // per-context state
  for (genvar g = 0; g < NCTX; g++) begin : g_ctx
    assign sel[g] = (req_ctx == CTX_W'(g));

    resv_slot #(.AW(AW), .GRAN_BITS(GRAN_BITS)) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (is_ll && sel[g]),
      .clr_own_i (sc_fail && sel[g]),
      .snoop_i   (perform),
      .gran_i    (req_gran),
      .hit_o     (hit_vec[g])
    );

    fail_tracker #(.FAIL_W(FAIL_W), .WARN_PERIOD(WARN_PERIOD)) trk_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .fail_i (sc_fail && sel[g]),
      .pass_i ((sc_pass || sc_unc) && sel[g]),
      .cnt_o  (cnt_arr[g]),
      .warn_o (warn_vec[g])
    );

    assign fail_count[g*FAIL_W +: FAIL_W] = cnt_arr[g];
  end

  // response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_sc_q    <= 1'b0;
      rsp_ok_q    <= 1'b0;
      rsp_code_q  <= SC_FAIL;
    end else begin
      rsp_valid_q <= req_valid;
      rsp_sc_q    <= is_sc;
      rsp_ok_q    <= perform;
      rsp_code_q  <= code_d;
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_sc       = rsp_sc_q;
  assign rsp_code     = rsp_code_q;
  assign rsp_store_ok = rsp_ok_q;

  assign warn_valid = |warn_vec;
  always_comb begin
    warn_ctx = '0;
    for (int i = 0; i < NCTX; i++)
      if (warn_vec[i]) warn_ctx = CTX_W'(i);
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R2
  AST_FAIL_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_sc && rsp_code == SC_FAIL) |-> !rsp_store_ok); // R3
  AST_UNCACHED_WRITES: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_code == SC_UNCACHED) |-> (rsp_store_ok && rsp_sc)); // R4
  AST_WARN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(warn_vec)); // R6
  AST_WARN_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n) warn_valid |-> (rsp_valid && rsp_sc)); // R6
  AST_NONSC_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_sc) |-> rsp_code == SC_FAIL); // R9
endmodule

// File: tb/resv_monitor_tb_top.sv
module resv_monitor_tb_top;
  localparam int NCTX   = 4;
  localparam int AW     = 32;
  localparam int FW     = 4;
  localparam int PERIOD = 5;
  localparam int CW     = 2;
  localparam int CMAX   = (1 << FW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [CW-1:0] req_ctx = '0;
  logic [AW-1:0] req_addr = '0;
  logic req_store = 1'b0, req_locked = 1'b0, req_uncached = 1'b0;
  logic rsp_valid, rsp_sc, rsp_store_ok, warn_valid;
  logic [1:0] rsp_code;
  logic [CW-1:0] warn_ctx;
  logic [NCTX*FW-1:0] fail_count;

  always #2.5 clk = ~clk;

  resv_monitor #(.NCTX(NCTX), .AW(AW), .GRAN_BITS(4), .FAIL_W(FW), .WARN_PERIOD(PERIOD)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ctx(req_ctx), .req_addr(req_addr), .req_store(req_store),
    .req_locked(req_locked), .req_uncached(req_uncached),
    .rsp_valid(rsp_valid), .rsp_sc(rsp_sc), .rsp_code(rsp_code),
    .rsp_store_ok(rsp_store_ok), .warn_valid(warn_valid), .warn_ctx(warn_ctx),
    .fail_count(fail_count)
  );

  typedef struct packed {
    logic [1:0]  code;
    logic        ok;
    logic        sc;
    logic        warn;
    logic [7:0]  ctx;
    logic [31:0] cnt;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    failures = 0;
  bit    done = 0;

  // model state, written from the requirements
  bit          m_flag [NCTX];
  logic [31:0] m_addr [NCTX];
  int          m_cnt  [NCTX];
  int          m_sub  [NCTX];

  task automatic check(bit good, string tag, string what, int act, int expv);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCTX; i++) begin
      m_flag[i] = 0; m_addr[i] = '0; m_cnt[i] = 0; m_sub[i] = 0;
    end
  endtask

  // driver: one request per call, expected result queued
  task automatic send(int ctx, logic [31:0] a, bit st, bit lk, bit unc, string tag);
    exp_t e;
    e = '0;
    e.ctx = 8'(ctx);
    if (!st && lk) begin
      m_flag[ctx] = 1; m_addr[ctx] = a;
    end else if (st && lk) begin
      e.sc = 1;
      if (unc) begin
        e.code = 2; e.ok = 1; m_cnt[ctx] = 0; m_sub[ctx] = 0;
      end else if (m_flag[ctx] && (m_addr[ctx][31:4] == a[31:4])) begin
        e.code = 1; e.ok = 1; m_cnt[ctx] = 0; m_sub[ctx] = 0;
      end else begin
        e.code = 0; e.ok = 0; m_flag[ctx] = 0;
        if (m_cnt[ctx] < CMAX) m_cnt[ctx]++;
        e.warn = (m_sub[ctx] == PERIOD - 1);
        m_sub[ctx] = e.warn ? 0 : m_sub[ctx] + 1;
      end
    end else if (st) begin
      e.ok = 1;
    end
    if (e.ok)
      for (int i = 0; i < NCTX; i++)
        if (m_addr[i][31:4] == a[31:4]) m_flag[i] = 0;
    e.cnt = 32'(m_cnt[ctx]);
    @(negedge clk);
    req_valid = 1; req_ctx = CW'(ctx); req_addr = a;
    req_store = st; req_locked = lk; req_uncached = unc;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  task automatic do_reset();
    idle(2);
    rst_n = 0;
    model_reset();
    repeat (2) @(negedge clk);
    check(rsp_valid == 0, "R8", "rsp_valid in reset", int'(rsp_valid), 0);
    check(warn_valid == 0, "R8", "warn_valid in reset", int'(warn_valid), 0);
    check(fail_count == '0, "R8", "fail_count in reset", int'(fail_count), 0);
    rst_n = 1;
  endtask

  // monitor: compare on the falling edge after the response edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R2", "unexpected response", 1, 0);
        end else begin
          exp_t e;
          string t;
          int cval;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          cval = int'(fail_count[int'(e.ctx)*FW +: FW]);
          check(rsp_code == e.code, t, "rsp_code", int'(rsp_code), int'(e.code));
          check(rsp_store_ok == e.ok, t, "rsp_store_ok", int'(rsp_store_ok), int'(e.ok));
          check(rsp_sc == e.sc, t, "rsp_sc", int'(rsp_sc), int'(e.sc));
          check(cval == int'(e.cnt), t, "fail_count", cval, int'(e.cnt));
          check(warn_valid == e.warn, t, "warn_valid", int'(warn_valid), int'(e.warn));
          if (e.warn)
            check(warn_ctx == CW'(e.ctx), "R6", "warn_ctx", int'(warn_ctx), int'(e.ctx));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();                                         // R8 reset state
    check(req_ready == 1, "R2", "req_ready", int'(req_ready), 1);

    send(0, 32'h100, 1, 1, 0, "R3");                    // SC with nothing reserved
    send(0, 32'h100, 0, 1, 0, "R1");                    // arm ctx0
    send(0, 32'h10C, 1, 1, 0, "R2");                    // same granule, low bits differ
    send(0, 32'h100, 1, 1, 0, "R7");                    // own store disarmed ctx0

    send(1, 32'h200, 0, 1, 0, "R1");
    send(2, 32'h204, 0, 1, 0, "R1");
    send(3, 32'h20F, 1, 0, 0, "R7");                    // plain store clears both
    send(1, 32'h200, 1, 1, 0, "R7");
    send(2, 32'h204, 1, 1, 0, "R7");

    send(0, 32'h300, 0, 1, 0, "R1");
    send(0, 32'h310, 1, 1, 0, "R3");                    // other granule fails
    send(0, 32'h300, 1, 1, 0, "R3");                    // flag now cleared

    send(1, 32'h400, 0, 1, 0, "R1");
    send(1, 32'h400, 0, 0, 0, "R9");                    // plain load
    send(1, 32'h400, 0, 0, 1, "R9");                    // uncached plain load
    send(1, 32'h400, 1, 1, 0, "R9");                    // reservation survived

    send(2, 32'h500, 1, 1, 0, "R3");
    send(2, 32'h500, 1, 1, 0, "R5");                    // count 2
    send(3, 32'h500, 0, 1, 0, "R1");
    send(2, 32'h508, 1, 1, 1, "R4");                    // uncached bypass
    send(3, 32'h500, 1, 1, 0, "R4");                    // ctx3 reservation cleared

    send(1, 32'h600, 1, 1, 1, "R4");                    // start ctx1 run from zero
    for (int k = 0; k < 20; k++)
      send(1, 32'h600, 1, 1, 0, (k % PERIOD == PERIOD - 1) ? "R6" : "R5");
    send(1, 32'h600, 0, 1, 0, "R1");
    send(1, 32'h600, 1, 1, 0, "R5");                    // success zeroes saturated count

    send(0, 32'h700, 0, 1, 0, "R1");
    idle(3);
    do_reset();
    send(0, 32'h700, 1, 1, 0, "R8");                    // reservation lost in reset
    idle(4);

    check(exp_q.size() == 0, "R2", "responses outstanding", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule